// File: doc/BRIEF.md
# Associative Page Address Translator

This block turns a word address in a single-level store into a physical core address. The address splits into two fields. The upper field is a block number and the lower field is the offset of a word inside that block. The block holds one page register for every core page. Each register holds the block number that is now resident in that page, together with a valid flag. A request compares its block number against every valid register in the same cycle. When one matches, the index of that page and the unchanged word offset together form the core address.

When nothing matches, the block reports non-equivalence. It keeps the faulting address and raises a level fault request to a fault-service controller. It also stalls the requester until the access can complete. The controller brings the block into some page and then writes that block number into the page's register through the load port. Every load made while a fault is pending re-runs the held access. The access is not dropped: it completes with a hit once the right register holds the block. Choosing a victim page and moving data are left to the controller.

Top module: `page_xlate`

## Requirements
- R1: Every page register has a valid flag that reset clears. An empty page never matches, so the first lookup after reset misses, and hit, fault and stall all read 0 right after reset.
- R2: A request address is 17 bits wide. Bits 16..9 are the block number and bits 8..0 are the word offset.
- R3: When a request is accepted and one valid register holds its block number, `hit_o` pulses high on the next cycle. `phys_addr_o` then equals page index × 512 + offset: the 5-bit page index sits in bits 13..9 and the offset is copied into bits 8..0.
- R4: A request whose block number matches no valid register pulses `miss_o` on the next cycle. From that cycle on, `fault_req_o` is held high and `fault_blk_o` shows the missing block number.
- R5: `hit_o` and `miss_o` are never high together.
- R6: While a fault is pending, `stall_o` is high and new requests are ignored. They produce no hit and leave `fault_blk_o` unchanged.
- R7: A load with `ld_en` high writes `ld_blk` into the register of page `ld_page` and marks it valid. A load made while a fault is pending retries the held access. The result of that retry appears two cycles after the load is presented, and a hit clears the fault.
- R8: A load whose block number is 192 or more is ignored. The register keeps its previous contents.
- R9: If several valid registers hold the requested block, the lowest-numbered page wins and `multi_err_o` is high in the same cycle as `hit_o`.
- R10: Loading a page replaces its old block number, and the old block no longer maps to that page.
- R11: A retry that still finds no match pulses `miss_o` again and keeps the fault pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_addr | input | 17 | Block number and word offset |
| ld_en | input | 1 | Page register load strobe |
| ld_page | input | 5 | Page whose register is loaded |
| ld_blk | input | 8 | Block number written on a load |
| hit_o | output | 1 | Equivalence, a one-cycle pulse |
| miss_o | output | 1 | Non-equivalence, a one-cycle pulse |
| phys_addr_o | output | 14 | Core address of the last hit |
| multi_err_o | output | 1 | More than one register matched |
| fault_req_o | output | 1 | Fault pending, held until serviced |
| fault_blk_o | output | 8 | Block number of the held access |
| stall_o | output | 1 | Requester must wait |

## Verification
The bench builds the block with its default parameters: 32 pages, 9 offset bits, 8 block bits and a limit of 192 blocks. It fills every page register and looks up each page, so the highest page index (31), the largest legal block number (188 in the fill pattern) and the extreme offsets 0 and 511 are all exercised. With the default block width, a load of block 200 is a real value the field can carry, which makes the out-of-range rejection testable. With the default page count, a duplicate entry can sit in pages that are far apart.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int NPAGE = 32,
  parameter int OFFW  = 9,
  parameter int BLKW  = 8,
  parameter int NBLK  = 192,
  localparam int PGW  = $clog2(NPAGE),
  localparam int AW   = BLKW + OFFW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic             ld_en,
  input  logic [PGW-1:0]   ld_page,
  input  logic [BLKW-1:0]  ld_blk,
  output logic             hit_o,
  output logic             miss_o,
  output logic [PGW+OFFW-1:0] phys_addr_o,
  output logic             multi_err_o,
  output logic             fault_req_o,
  output logic [BLKW-1:0]  fault_blk_o,
  output logic             stall_o
);

  logic [BLKW-1:0]  par_q [NPAGE];
  logic [NPAGE-1:0] vld_q;
  logic             fault_q, retry_q;
  logic [AW-1:0]    acc_q;
  logic [NPAGE-1:0] match;
  logic [PGW-1:0]   first;
  logic             found, multi;

  wire           look_go   = fault_q ? retry_q : req_valid;
  wire [AW-1:0]  look_addr = fault_q ? acc_q : req_addr;
  wire [BLKW-1:0] look_blk = look_addr[AW-1:OFFW];
  wire           ld_ok     = ld_en && ({1'b0, ld_blk} < (BLKW+1)'(NBLK));

  for (genvar g = 0; g < NPAGE; g++) begin : g_cmp
    assign match[g] = vld_q[g] && (par_q[g] == look_blk);
  end

  always_comb begin
    first = '0;
    for (int i = NPAGE - 1; i >= 0; i--)
      if (match[i]) first = PGW'(i);
  end

  assign found = |match;
  assign multi = |(match & (match - NPAGE'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q       <= '0;
      for (int i = 0; i < NPAGE; i++) par_q[i] <= '0;
      fault_q     <= 1'b0;
      retry_q     <= 1'b0;
      acc_q       <= '0;
      hit_o       <= 1'b0;
      miss_o      <= 1'b0;
      multi_err_o <= 1'b0;
      phys_addr_o <= '0;
    end else begin
      if (ld_ok) begin
        par_q[ld_page] <= ld_blk;
        vld_q[ld_page] <= 1'b1;
      end
      retry_q     <= fault_q && ld_en;
      hit_o       <= look_go && found;
      miss_o      <= look_go && !found;
      multi_err_o <= look_go && found && multi;
      if (look_go) begin
        fault_q <= !found;
        if (found) phys_addr_o <= {first, look_addr[OFFW-1:0]};
        if (!fault_q) acc_q <= req_addr;
      end
    end
  end

  assign fault_req_o = fault_q;
  assign fault_blk_o = acc_q[AW-1:OFFW];
  assign stall_o     = fault_q | retry_q;

  assert_one_outcome_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_o && miss_o));

  assert_miss_raises_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
    miss_o |-> fault_req_o);

  assert_fault_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req_o && !retry_q) |=> fault_req_o);

  assert_held_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req_o |=> $stable(fault_blk_o));

  assert_err_with_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    multi_err_o |-> hit_o);

  assert_offset_passes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> phys_addr_o[OFFW-1:0] == $past(look_addr[OFFW-1:0]));

  assert_load_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_req_o && ld_en) |=> stall_o);

endmodule

// File: tb/sim_page_xlate.sv
module sim_page_xlate;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, ld_en = 0;
  logic [16:0] req_addr = '0;
  logic [4:0]  ld_page = '0;
  logic [7:0]  ld_blk = '0;
  logic        hit_o, miss_o, multi_err_o, fault_req_o, stall_o;
  logic [13:0] phys_addr_o;
  logic [7:0]  fault_blk_o;
  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  page_xlate u0 (.clk, .rst_n, .req_valid, .req_addr, .ld_en, .ld_page, .ld_blk,
                 .hit_o, .miss_o, .phys_addr_o, .multi_err_o, .fault_req_o,
                 .fault_blk_o, .stall_o);

  // {block, offset, page}: all expected hits after the fill pattern blk = 6*page+2
  localparam logic [21:0] VEC [8] = '{
    {8'd2,   9'd0,   5'd0},  {8'd8,   9'd1,   5'd1},
    {8'd188, 9'd511, 5'd31}, {8'd62,  9'h155, 5'd10},
    {8'd74,  9'd3,   5'd12}, {8'd56,  9'd9,   5'd9},
    {8'd98,  9'd256, 5'd16}, {8'd128, 9'd77,  5'd21}};

  task automatic chk(string tag, int got, int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic lookup(input logic [7:0] b, input logic [8:0] o);
    @(negedge clk); req_valid = 1; req_addr = {b, o};
    @(negedge clk); req_valid = 0;
  endtask

  task automatic load(input logic [4:0] p, input logic [7:0] b);
    @(negedge clk); ld_en = 1; ld_page = p; ld_blk = b;
    @(negedge clk); ld_en = 0;
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 hit after reset", hit_o, 0);
    chk("R1 fault after reset", fault_req_o, 0);
    chk("R1 stall after reset", stall_o, 0);

    lookup(8'd5, 9'd419);
    chk("R1 empty page miss", hit_o, 0);
    chk("R4 miss pulse", miss_o, 1);
    chk("R4 fault level", fault_req_o, 1);
    chk("R4 fault block", fault_blk_o, 5);

    lookup(8'd7, 9'd1);
    chk("R6 stall", stall_o, 1);
    chk("R6 request ignored", hit_o, 0);
    chk("R6 held block", fault_blk_o, 5);

    load(5'd9, 8'd3);
    @(negedge clk);
    chk("R11 retry miss", miss_o, 1);
    chk("R11 fault kept", fault_req_o, 1);

    load(5'd12, 8'd5);
    @(negedge clk);
    chk("R7 retry hit", hit_o, 1);
    chk("R7 retry phys", phys_addr_o, 12*512 + 419);
    chk("R7 fault cleared", fault_req_o, 0);
    chk("R7 stall cleared", stall_o, 0);

    for (int p = 0; p < 32; p++) load(5'(p), 8'(6*p + 2));
    for (int p = 0; p < 32; p++) begin
      lookup(8'(6*p + 2), 9'(p*13));
      chk("R3 sweep hit", hit_o, 1);
      chk("R3 sweep phys", phys_addr_o, p*512 + p*13);
    end

    for (int v = 0; v < 8; v++) begin
      lookup(VEC[v][21:14], VEC[v][13:5]);
      chk("R3 table hit", hit_o, 1);
      chk("R2 table phys", phys_addr_o, VEC[v][4:0]*512 + VEC[v][13:5]);
      chk("R9 no error single", multi_err_o, 0);
    end

    load(5'd3, 8'd200);
    lookup(8'd20, 9'd6);
    chk("R8 rejected load hit", hit_o, 1);
    chk("R8 rejected load phys", phys_addr_o, 3*512 + 6);

    lookup(8'd5, 9'd2);
    chk("R10 old block gone", miss_o, 1);
    load(5'd7, 8'd5);
    @(negedge clk);
    chk("R10 new page hit", phys_addr_o, 7*512 + 2);

    load(5'd2, 8'd5);
    lookup(8'd5, 9'd44);
    chk("R9 lowest page", phys_addr_o, 2*512 + 44);
    chk("R9 multi flag", multi_err_o, 1);
    chk("R5 single outcome", hit_o + miss_o, 1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule